// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interface of a parallel NOR-style flash. It watches every bus write (address and data) and recognises multi-cycle unlock sequences. These sequences enter autoselect, start a word program, start a sector erase, and load the burst configuration register. It keeps the bank mode, and it tells the read path whether a read at a given address may proceed.

The embedded program and erase algorithms are not modelled. A single `op_busy` input stands in for them and stays high while such an operation, or a sector-lock operation, runs. An `err_flag` input stands in for the operation-failed status bit.

The burst configuration code is not taken from the data bus. It is taken from address bits [19:12] of the final write. The block decodes the code into its fields, and it raises synchronous mode only after a load has actually taken place.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After hardware reset, `mode` is 0 (array read), `cfg_code` holds the default 00h, and `sync_en` is 0.
- R2: An unlock is a write of AAh to address 555h, followed by a write of 55h to address 2AAh. Only address bits [11:0] and data bits [7:0] are compared, so higher address bits do not matter.
- R3: An unlock followed by a write of C0h to address 555h loads address bits [19:12] into `cfg_code`. The fields are decoded as follows: bit 7 is the synchronous enable, bits [6:4] give `wait_states`, bit 3 gives `burst_mode`, bit 2 gives `clk_edge`, and bit 1 gives `rdy_timing`. The mode does not change.
- R4: `sync_en` is 1 only when a configuration load has happened since reset and the loaded bit 7 is 1.
- R5: A configuration load is refused when `op_busy` is high or an erase is suspended. A refused load leaves `cfg_code` and `mode` unchanged.
- R6: A write whose address or data does not fit the current sequence step puts `mode` at 4 (undefined). The block stays there through every write other than F0h.
- R7: A write of F0h to any address clears any partial unlock progress. From autoselect or from the undefined mode, it returns `mode` to 0, or to 2 if an erase is suspended.
- R8: An unlock followed by 90h at 555h sets `mode` to 1 (autoselect). In that mode, every write other than F0h is ignored.
- R9: An unlock followed by A0h at 555h, then one data write, sets `mode` to 3 (busy). While `mode` is 3, `rd_ok` is 0. When `op_busy` is seen low in mode 3, the block returns to mode 0, or to mode 2 if the program was issued during an erase suspend. In mode 0, `rd_ok` is 1.
- R10: An unlock, then 80h at 555h, a second unlock, and 30h at a sector address starts an erase (`mode` 3). The sector is address bits [19:15]. A write of B0h during the erase suspends it (`mode` 2). A write of 30h while suspended resumes it (`mode` 3).
- R11: In mode 2, `rd_ok` is 1 exactly when bits [19:15] of `rd_addr` differ from the suspended sector.
- R12: In mode 3, F0h is honoured only while `err_flag` is high. It then returns to mode 0, or to mode 2 for a program issued during a suspend. Without `err_flag`, F0h leaves mode 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data |
| op_busy | input | 1 | Embedded program, erase or lock operation running |
| err_flag | input | 1 | Embedded operation failed |
| rd_addr | input | 20 | Address of the read being qualified |
| mode | output | 3 | 0 read, 1 autoselect, 2 erase-suspend read, 3 busy, 4 undefined |
| rd_ok | output | 1 | Read at `rd_addr` is allowed |
| cfg_code | output | 8 | Burst configuration code |
| sync_en | output | 1 | Synchronous burst mode enabled |
| wait_states | output | 3 | Wait-state count field |
| burst_mode | output | 1 | Burst read mode field |
| clk_edge | output | 1 | Active clock edge field |
| rdy_timing | output | 1 | Ready timing field |

## Verification
The configuration load is swept over all 256 codes carried in the high address bits. Each field is compared against bit slices of the sweep index, so a shifted or swapped field shows up.

Wrong-address cases are swept bit by bit on the first and second unlock writes. This separates full 12-bit address comparison from a partial comparison.

The bank-state paths are walked in turn: program, erase, suspend, program during suspend, resume, and reset with and without the error flag. This separates return-to-read from return-to-suspend-read.

In suspend-read, all 32 sectors are swept, which tells the suspended sector apart from its neighbours.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CFG_LSB = 12,
  parameter int SECT_LSB = 15,
  parameter logic [7:0] CFG_DEFAULT = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_busy,
  input  logic              err_flag,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        mode,
  output logic              rd_ok,
  output logic [7:0]        cfg_code,
  output logic              sync_en,
  output logic [2:0]        wait_states,
  output logic              burst_mode,
  output logic              clk_edge,
  output logic              rdy_timing
);
  localparam int SECT_W = ADDR_W - SECT_LSB;

  typedef enum logic [2:0] {
    M_READ = 3'd0, M_ASEL = 3'd1, M_SUSP = 3'd2, M_BUSY = 3'd3, M_UNK = 3'd4
  } mode_t;

  typedef enum logic [2:0] {
    Q_IDLE, Q_U1, Q_U2, Q_PGM, Q_E1, Q_E2, Q_E3
  } seq_t;

  mode_t             mode_q, mode_d;
  seq_t              seq_q, seq_d;
  logic              susp_q, susp_d;
  logic              prog_q, prog_d;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [7:0]        cfg_q, cfg_d;
  logic              cfg_set_q, cfg_set_d;

  wire [11:0] a12    = wr_addr[11:0];
  wire [7:0]  cmd    = wr_data[7:0];
  wire        at555  = (a12 == 12'h555);
  wire        at2aa  = (a12 == 12'h2AA);
  wire        is_rst = (cmd == 8'hF0);
  wire [SECT_W-1:0] wr_sect = wr_addr[ADDR_W-1:SECT_LSB];
  wire [SECT_W-1:0] rd_sect = rd_addr[ADDR_W-1:SECT_LSB];
  wire mode_home = susp_q ? M_SUSP : M_READ;

  always_comb begin
    mode_d    = mode_q;
    seq_d     = seq_q;
    susp_d    = susp_q;
    prog_d    = prog_q;
    sect_d    = sect_q;
    cfg_d     = cfg_q;
    cfg_set_d = cfg_set_q;
    case (mode_q)
      M_BUSY: begin
        if (!op_busy) begin
          if (prog_q && susp_q) begin
            mode_d = M_SUSP;
          end else begin
            mode_d = M_READ;
            susp_d = 1'b0;
          end
        end else if (wr_en && is_rst && err_flag) begin
          if (prog_q && susp_q) begin
            mode_d = M_SUSP;
          end else begin
            mode_d = M_READ;
            susp_d = 1'b0;
          end
        end else if (wr_en && cmd == 8'hB0 && !prog_q) begin
          mode_d = M_SUSP;
          susp_d = 1'b1;
        end
      end
      M_ASEL, M_UNK: begin
        if (wr_en && is_rst) begin
          mode_d = susp_q ? M_SUSP : M_READ;
          seq_d  = Q_IDLE;
        end
      end
      default: begin
        if (wr_en) begin
          if (is_rst) begin
            seq_d = Q_IDLE;
          end else begin
            seq_d = Q_IDLE;
            case (seq_q)
              Q_IDLE: begin
                if (cmd == 8'hAA && at555) seq_d = Q_U1;
                else if (mode_q == M_SUSP && cmd == 8'h30) begin
                  mode_d = M_BUSY;
                  prog_d = 1'b0;
                  susp_d = 1'b0;
                end else mode_d = M_UNK;
              end
              Q_U1: begin
                if (cmd == 8'h55 && at2aa) seq_d = Q_U2;
                else mode_d = M_UNK;
              end
              Q_U2: begin
                if (!at555) mode_d = M_UNK;
                else begin
                  case (cmd)
                    8'hA0: seq_d = Q_PGM;
                    8'h80: begin
                      if (susp_q) mode_d = M_UNK;
                      else seq_d = Q_E1;
                    end
                    8'h90: mode_d = M_ASEL;
                    8'hC0: begin
                      if (!op_busy && !susp_q) begin
                        cfg_d     = wr_addr[CFG_LSB +: 8];
                        cfg_set_d = 1'b1;
                      end
                    end
                    default: mode_d = M_UNK;
                  endcase
                end
              end
              Q_PGM: begin
                mode_d = M_BUSY;
                prog_d = 1'b1;
              end
              Q_E1: begin
                if (cmd == 8'hAA && at555) seq_d = Q_E2;
                else mode_d = M_UNK;
              end
              Q_E2: begin
                if (cmd == 8'h55 && at2aa) seq_d = Q_E3;
                else mode_d = M_UNK;
              end
              Q_E3: begin
                if (cmd == 8'h30) begin
                  mode_d = M_BUSY;
                  prog_d = 1'b0;
                  sect_d = wr_sect;
                end else mode_d = M_UNK;
              end
              default: mode_d = M_UNK;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_READ;
      seq_q     <= Q_IDLE;
      susp_q    <= 1'b0;
      prog_q    <= 1'b0;
      sect_q    <= '0;
      cfg_q     <= CFG_DEFAULT;
      cfg_set_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      seq_q     <= seq_d;
      susp_q    <= susp_d;
      prog_q    <= prog_d;
      sect_q    <= sect_d;
      cfg_q     <= cfg_d;
      cfg_set_q <= cfg_set_d;
    end
  end

  assign mode        = mode_q;
  assign rd_ok       = (mode_q == M_READ) || (mode_q == M_ASEL) ||
                       ((mode_q == M_SUSP) && (rd_sect != sect_q));
  assign cfg_code    = cfg_q;
  assign sync_en     = cfg_set_q & cfg_q[7];
  assign wait_states = cfg_q[6:4];
  assign burst_mode  = cfg_q[3];
  assign clk_edge    = cfg_q[2];
  assign rdy_timing  = cfg_q[1];

  logic unused_ok;
  assign unused_ok = &{1'b0, mode_home, wr_data[DATA_W-1:8]};
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter logic [7:0] CFG_DEFAULT = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              op_busy,
  input logic [2:0]        mode,
  input logic              rd_ok,
  input logic [7:0]        cfg_code,
  input logic              sync_en
);
  always @(posedge clk)
    if (!rst_n)
      a_r1_reset_state: assert (mode == 3'd0 && cfg_code == CFG_DEFAULT && !sync_en);

  a_r4_sync_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_en) |-> $past(wr_en && wr_data[7:0] == 8'hC0));

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy || mode == 3'd3) |=> $stable(cfg_code));

  a_r6_unknown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !(wr_en && wr_data[7:0] == 8'hF0)) |=> mode == 3'd4);

  a_r9_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd3 |-> !rd_ok);

  a_r9_read_mode_ok: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd0 |-> rd_ok);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_DEFAULT(CFG_DEFAULT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .op_busy(op_busy), .mode(mode), .rd_ok(rd_ok), .cfg_code(cfg_code),
  .sync_en(sync_en)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        op_busy = 1'b0;
  logic        err_flag = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [2:0]  mode;
  logic        rd_ok;
  logic [7:0]  cfg_code;
  logic        sync_en;
  logic [2:0]  wait_states;
  logic        burst_mode, clk_edge, rdy_timing;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_cfg;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_busy(op_busy), .err_flag(err_flag),
    .rd_addr(rd_addr), .mode(mode), .rd_ok(rd_ok), .cfg_code(cfg_code),
    .sync_en(sync_en), .wait_states(wait_states), .burst_mode(burst_mode),
    .clk_edge(clk_edge), .rdy_timing(rdy_timing)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = {8'h5A, d};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(20'h00555, 8'hAA);
    wr(20'h002AA, 8'h55);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    hw_reset();
    check("R1 mode", mode, 0);
    check("R1 cfg", cfg_code, 8'h00);
    check("R1 sync", sync_en, 0);
    check("R9 rd_ok in read", rd_ok, 1);

    unlock(); wr({8'h7E, 12'h555}, 8'hC0);
    check("R4 sync bit7 clear", sync_en, 0);
    unlock(); wr({8'h80, 12'h555}, 8'hC0);
    check("R4 sync after load", sync_en, 1);

    for (int c = 0; c < 256; c++) begin
      unlock(); wr({c[7:0], 12'h555}, 8'hC0);
      check("R3 code", cfg_code, c);
      check("R3 waits", wait_states, (c >> 4) & 7);
      check("R3 burst", burst_mode, (c >> 3) & 1);
      check("R3 edge", clk_edge, (c >> 2) & 1);
      check("R3 rdy", rdy_timing, (c >> 1) & 1);
      check("R4 sync", sync_en, (c >> 7) & 1);
      check("R3 mode kept", mode, 0);
    end
    exp_cfg = 8'hFF;

    wr(20'hFF555, 8'hAA); wr(20'h3A2AA, 8'h55); wr(20'h00555, 8'h90);
    check("R2 R8 autoselect", mode, 1);
    wr(20'h00555, 8'hAA);
    check("R8 write ignored", mode, 1);
    wr(20'h12345, 8'hF0);
    check("R7 exit autoselect", mode, 0);

    wr(20'h00555, 8'hAA); wr(20'h00000, 8'hF0); wr(20'h002AA, 8'h55);
    check("R7 progress cleared", mode, 4);
    wr(20'h00555, 8'hAA);
    check("R6 sticky", mode, 4);
    check("R6 rd_ok", rd_ok, 0);
    wr(20'h00000, 8'hF0);
    check("R7 exit undefined", mode, 0);

    for (int b = 0; b < 12; b++) begin
      wr(20'h00555 ^ (20'h1 << b), 8'hAA);
      check("R6 first addr", mode, 4);
      wr(20'h0, 8'hF0);
      wr(20'h00555, 8'hAA); wr(20'h002AA ^ (20'h1 << b), 8'h55);
      check("R6 second addr", mode, 4);
      wr(20'h0, 8'hF0);
      check("R7 back", mode, 0);
    end
    unlock(); wr(20'h00555, 8'h77);
    check("R6 bad command", mode, 4);
    wr(20'h0, 8'hF0);

    op_busy = 1'b1;
    unlock(); wr({8'h95, 12'h555}, 8'hC0);
    check("R5 refused busy", cfg_code, exp_cfg);
    check("R5 mode", mode, 0);

    unlock(); wr(20'h00555, 8'hA0); wr(20'h01234, 8'h3C);
    check("R9 program busy", mode, 3);
    check("R9 rd_ok busy", rd_ok, 0);
    wr(20'h0, 8'hF0);
    check("R12 reset w/o err", mode, 3);
    op_busy = 1'b0; idle();
    check("R9 done", mode, 0);

    op_busy = 1'b1;
    unlock(); wr(20'h00555, 8'hA0); wr(20'h01234, 8'h3C);
    err_flag = 1'b1;
    wr(20'h0, 8'hF0);
    check("R12 reset with err", mode, 0);
    err_flag = 1'b0;

    unlock(); wr(20'h00555, 8'h80); unlock(); wr(20'h5 << 15, 8'h30);
    check("R10 erase busy", mode, 3);
    wr(20'h0, 8'hB0);
    check("R10 suspend", mode, 2);
    for (int s = 0; s < 32; s++) begin
      rd_addr = (20'(s) << 15) | 20'(s * 3);
      #1;
      check("R11 sector read", rd_ok, (s != 5) ? 1 : 0);
    end
    rd_addr = '0;
    op_busy = 1'b0;
    unlock(); wr({8'h44, 12'h555}, 8'hC0);
    check("R5 refused suspend", cfg_code, exp_cfg);
    check("R5 suspend mode", mode, 2);
    op_busy = 1'b1;
    unlock(); wr(20'h00555, 8'hA0); wr(20'h08000, 8'h11);
    check("R9 program in suspend", mode, 3);
    op_busy = 1'b0; idle();
    check("R9 back to suspend", mode, 2);
    op_busy = 1'b1;
    unlock(); wr(20'h00555, 8'hA0); wr(20'h08000, 8'h11);
    err_flag = 1'b1;
    wr(20'h0, 8'hF0);
    check("R12 err to suspend", mode, 2);
    err_flag = 1'b0;
    wr(20'h0, 8'h30);
    check("R10 resume", mode, 3);
    op_busy = 1'b0; idle();
    check("R10 erase done", mode, 0);
    check("R11 read after erase", rd_ok, 1);

    hw_reset();
    check("R1 mode again", mode, 0);
    check("R1 cfg again", cfg_code, 8'h00);
    check("R4 sync cleared", sync_en, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule